// File: doc/BRIEF.md
# Eye Region Pyramid Downscaler

This block turns a detected face box into eight small eye images that a later classifier can scan. Given the inclusive corners of the face (left, top, right, bottom), it treats the upper half of the box as two quadrants. The upper-left quadrant holds the left eye and the upper-right quadrant holds the right eye. The frame memory can return only one pixel per clock. The block therefore makes a single serial pass per eye to resample the quadrant, by nearest-neighbour selection, into a 33-column by 36-row register image (level 0).

The right quadrant is read from its rightmost column towards its left. The stored right image is therefore already mirrored and needs no separate flip step. The three smaller levels (31x34, 29x32 and 27x29, columns x rows) are then resampled from the level-0 registers, not from memory. All four levels of both eyes stream out at the same time, each on its own valid line in raster order. A single done pulse closes the conversion. Source coordinates come from fixed-point step accumulators, with no divider in the datapath. A quadrant smaller than the target is enlarged by repeating pixels.

The control is one state machine:

- IDLE goes to SETUP on a start pulse, and the face corners are captured.
- SETUP computes the quadrant size and the fixed-point steps, then goes to FETCH_L.
- FETCH_L reads the left quadrant, then goes to FETCH_R.
- FETCH_R reads the mirrored right quadrant, then goes to DRAIN.
- DRAIN lets the last read land and launches the level streams, then goes to EMIT.
- EMIT runs until the final level-0 beat has been issued, then goes to FLUSH.
- FLUSH presents that beat, then returns to IDLE, where done is raised.

Top module: `eyepyr_top`

## Requirements
- R1: While reset is held, and until a start pulse arrives after it, busy, done, mem_rd_en and every pix_valid bit are 0.
- R2: A conversion issues exactly 2*33*36 memory reads, one per clock with no gap. All 1188 reads of the left quadrant come before any read of the right quadrant. mem_rdata is taken one clock after the cycle that asserts mem_rd_en. No read occurs while pixels are being emitted.
- R3: Left level-0 pixel at row i, column j equals the frame pixel at x = left + floor(j*QW/33), y = top + floor(i*QH/36).
- R4: Right level-0 pixel at row i, column j equals the frame pixel at x = right - floor(j*QW/33), y = top + floor(i*QH/36), giving a horizontally mirrored image.
- R5: Level k (k=1..3, size Wk columns x Hk rows: 31x34, 29x32, 27x29) pixel (i,j) equals the level-0 pixel of the same eye at row floor(i*36/Hk) and column floor(j*33/Wk).
- R6: The four levels start in the same cycle. Level k is valid for exactly Wk*Hk consecutive cycles, in raster order (row-major, column 0 first). Left and right pixels of level k share pix_valid[k], and level k's pixels sit at bits [8k+7:8k] of left_pix and right_pix.
- R7: done is a one-cycle pulse in the cycle after the last level-0 beat, and busy is 0 from that cycle on.
- R8: A start pulse while busy is 1 is ignored: the running conversion completes with its original face box and only one done pulse.
- R9: When a quadrant is smaller than the target size, output pixels follow the same formulas, so source pixels are repeated.
- R10: Quadrant width QW = floor((right-left+1)/2) and height QH = floor((bottom-top+1)/2). Every memory read lies in rows top..top+QH-1 and in the quadrant's own columns, addressed as the formulas of R3 and R4 give in raster order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; face corners sampled with it |
| face_left | input | CW | Leftmost face column (inclusive) |
| face_top | input | CW | Top face row (inclusive) |
| face_right | input | CW | Rightmost face column (inclusive) |
| face_bottom | input | CW | Bottom face row (inclusive) |
| mem_rd_en | output | 1 | Frame memory read strobe |
| mem_x | output | CW | Read column address |
| mem_y | output | CW | Read row address |
| mem_rdata | input | PW | Read data, one clock after the strobe |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| pix_valid | output | 4 | Per-level beat valid |
| left_pix | output | 4*PW | Left-eye pixel of each level |
| right_pix | output | 4*PW | Right-eye pixel of each level |

## Verification
The hardest case to reach from the ports is a start pulse that lands while a conversion is running, in each of its two long phases: the serial fetch and the parallel emission. The directed test keeps counting cycles after its own start and injects a second start with a different face box. The first injection comes about 500 cycles in, during the fetch. The second comes about 3000 cycles in, after the streams have begun. The bench then compares every emitted pixel against the original box, and requires exactly one done pulse.

// File: rtl/eyepyr_pkg.sv
package eyepyr_pkg;

    localparam int NUM_LEVELS = 4;
    localparam int LVL_W [NUM_LEVELS] = '{33, 31, 29, 27};
    localparam int LVL_H [NUM_LEVELS] = '{36, 34, 32, 29};
    localparam int STEP_FRAC = 24;

    // ceil(num * 2^frac / den) as an unsigned fixed-point step
    function automatic longint unsigned ceil_ratio(input int num, input int den, input int frac);
        longint unsigned scaled;
        scaled = longint'(num) << frac;
        return (scaled + longint'(den) - 1) / longint'(den);
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FETCH_L,
        ST_FETCH_R,
        ST_DRAIN,
        ST_EMIT,
        ST_FLUSH
    } pyr_state_t;

endpackage

// File: rtl/eyepyr_step_acc.sv
module eyepyr_step_acc #(
    parameter int IW = 10,
    parameter int FW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [IW+FW-1:0] step,
    output logic [IW-1:0]    idx
);
    logic [IW+FW-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= acc_q + step;
        end
    end

    assign idx = acc_q[FW +: IW];
endmodule

// File: rtl/eyepyr_level_stream.sv
module eyepyr_level_stream #(
    parameter int OUT_W = 31,
    parameter int OUT_H = 34,
    parameter int SRC_W = 33,
    parameter int SRC_H = 36,
    parameter int FW    = 24,
    localparam int CIW  = $clog2(SRC_W),
    localparam int RIW  = $clog2(SRC_H)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    output logic           active,
    output logic           last,
    output logic [CIW-1:0] src_col,
    output logic [RIW-1:0] src_row
);
    import eyepyr_pkg::*;

    localparam int CCW = $clog2(OUT_W);
    localparam int RCW = $clog2(OUT_H);
    localparam logic [CIW+FW-1:0] COL_STEP = (CIW+FW)'(ceil_ratio(SRC_W, OUT_W, FW));
    localparam logic [RIW+FW-1:0] ROW_STEP = (RIW+FW)'(ceil_ratio(SRC_H, OUT_H, FW));

    logic [CCW-1:0] col_q;
    logic [RCW-1:0] row_q;
    logic           col_end, row_end;

    assign col_end = (col_q == CCW'(OUT_W - 1));
    assign row_end = (row_q == RCW'(OUT_H - 1));
    assign last    = active && col_end && row_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            col_q  <= '0;
            row_q  <= '0;
        end else if (launch) begin
            active <= 1'b1;
            col_q  <= '0;
            row_q  <= '0;
        end else if (active) begin
            if (col_end) begin
                col_q <= '0;
                if (row_end) begin
                    active <= 1'b0;
                end else begin
                    row_q <= row_q + 1'b1;
                end
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    eyepyr_step_acc #(.IW(CIW), .FW(FW)) u_col_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch || (active && col_end)),
        .advance (active && !col_end),
        .step    (COL_STEP),
        .idx     (src_col)
    );

    eyepyr_step_acc #(.IW(RIW), .FW(FW)) u_row_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch || last),
        .advance (active && col_end && !row_end),
        .step    (ROW_STEP),
        .idx     (src_row)
    );
endmodule

// File: rtl/eyepyr_top.sv
module eyepyr_top
    import eyepyr_pkg::*;
#(
    parameter int CW = 10,
    parameter int PW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CW-1:0]            face_left,
    input  logic [CW-1:0]            face_top,
    input  logic [CW-1:0]            face_right,
    input  logic [CW-1:0]            face_bottom,
    output logic                     mem_rd_en,
    output logic [CW-1:0]            mem_x,
    output logic [CW-1:0]            mem_y,
    input  logic [PW-1:0]            mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [NUM_LEVELS-1:0]    pix_valid,
    output logic [NUM_LEVELS*PW-1:0] left_pix,
    output logic [NUM_LEVELS*PW-1:0] right_pix
);
    localparam int W0   = LVL_W[0];
    localparam int H0   = LVL_H[0];
    localparam int L0_N = W0 * H0;
    localparam int AWD  = $clog2(L0_N);
    localparam int FCW  = $clog2(W0);
    localparam int FRW  = $clog2(H0);
    localparam int SAW  = CW + STEP_FRAC;
    localparam logic [SAW-1:0] RCP_W = SAW'(ceil_ratio(1, W0, STEP_FRAC));
    localparam logic [SAW-1:0] RCP_H = SAW'(ceil_ratio(1, H0, STEP_FRAC));

    pyr_state_t state_q, state_nx;

    logic [CW-1:0]  box_l_q, box_t_q, box_r_q, box_b_q;
    logic [SAW-1:0] col_step_q, row_step_q;
    logic [CW:0]    span_w, span_h;
    logic [FCW-1:0] fcol_q;
    logic [FRW-1:0] frow_q;
    logic           fcol_end, frow_end, fetching, launch;
    logic [CW-1:0]  fcol_idx, frow_idx;
    logic           wr_v_q, wr_right_q;
    logic [AWD-1:0] wr_addr_q;
    logic           done_q;
    logic [NUM_LEVELS-1:0] lvl_last;

    logic [PW-1:0] l0_left  [L0_N];
    logic [PW-1:0] l0_right [L0_N];

    // Quadrant size: half of the inclusive face span
    assign span_w = {1'b0, box_r_q} - {1'b0, box_l_q} + 1'b1;
    assign span_h = {1'b0, box_b_q} - {1'b0, box_t_q} + 1'b1;

    assign fcol_end = (fcol_q == FCW'(W0 - 1));
    assign frow_end = (frow_q == FRW'(H0 - 1));

    // State register, captured box, steps, done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            box_l_q    <= '0;
            box_t_q    <= '0;
            box_r_q    <= '0;
            box_b_q    <= '0;
            col_step_q <= '0;
            row_step_q <= '0;
            done_q     <= 1'b0;
        end else begin
            state_q <= state_nx;
            done_q  <= (state_q == ST_FLUSH);
            if (state_q == ST_IDLE && start) begin
                box_l_q <= face_left;
                box_t_q <= face_top;
                box_r_q <= face_right;
                box_b_q <= face_bottom;
            end
            if (state_q == ST_SETUP) begin
                col_step_q <= SAW'(span_w[CW:1]) * RCP_W;
                row_step_q <= SAW'(span_h[CW:1]) * RCP_H;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = ST_FETCH_L;
            ST_FETCH_L: if (fcol_end && frow_end) state_nx = ST_FETCH_R;
            ST_FETCH_R: if (fcol_end && frow_end) state_nx = ST_DRAIN;
            ST_DRAIN:   state_nx = ST_EMIT;
            ST_EMIT:    if (lvl_last[0]) state_nx = ST_FLUSH;
            ST_FLUSH:   state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        fetching  = (state_q == ST_FETCH_L) || (state_q == ST_FETCH_R);
        launch    = (state_q == ST_DRAIN);
        busy      = (state_q != ST_IDLE);
        mem_rd_en = fetching;
        done      = done_q;
        mem_y     = box_t_q + frow_idx;
        mem_x     = (state_q == ST_FETCH_R) ? (box_r_q - fcol_idx) : (box_l_q + fcol_idx);
    end

    // Fetch raster counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcol_q <= '0;
            frow_q <= '0;
        end else if (state_q == ST_SETUP) begin
            fcol_q <= '0;
            frow_q <= '0;
        end else if (fetching) begin
            if (fcol_end) begin
                fcol_q <= '0;
                frow_q <= frow_end ? '0 : frow_q + 1'b1;
            end else begin
                fcol_q <= fcol_q + 1'b1;
            end
        end
    end

    eyepyr_step_acc #(.IW(CW), .FW(STEP_FRAC)) u_fetch_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == ST_SETUP) || (fetching && fcol_end)),
        .advance (fetching && !fcol_end),
        .step    (col_step_q),
        .idx     (fcol_idx)
    );

    eyepyr_step_acc #(.IW(CW), .FW(STEP_FRAC)) u_fetch_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == ST_SETUP) || (fetching && fcol_end && frow_end)),
        .advance (fetching && fcol_end && !frow_end),
        .step    (row_step_q),
        .idx     (frow_idx)
    );

    // Read-return alignment: data arrives one clock after the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_v_q     <= 1'b0;
            wr_right_q <= 1'b0;
            wr_addr_q  <= '0;
        end else begin
            wr_v_q     <= fetching;
            wr_right_q <= (state_q == ST_FETCH_R);
            wr_addr_q  <= AWD'(frow_q) * AWD'(W0) + AWD'(fcol_q);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_v_q) begin
            if (wr_right_q) begin
                l0_right[wr_addr_q] <= mem_rdata;
            end else begin
                l0_left[wr_addr_q]  <= mem_rdata;
            end
        end
    end

    // Parallel level streams, all resampled from the level-0 registers
    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
        localparam int SCW = $clog2(W0);
        localparam int SRW = $clog2(H0);
        logic           act;
        logic [SCW-1:0] s_col;
        logic [SRW-1:0] s_row;
        logic [AWD-1:0] rd_addr;

        eyepyr_level_stream #(
            .OUT_W (LVL_W[k]),
            .OUT_H (LVL_H[k]),
            .SRC_W (W0),
            .SRC_H (H0),
            .FW    (STEP_FRAC)
        ) u_stream (
            .clk     (clk),
            .rst_n   (rst_n),
            .launch  (launch),
            .active  (act),
            .last    (lvl_last[k]),
            .src_col (s_col),
            .src_row (s_row)
        );

        assign rd_addr = AWD'(s_row) * AWD'(W0) + AWD'(s_col);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pix_valid[k]          <= 1'b0;
                left_pix[k*PW +: PW]  <= '0;
                right_pix[k*PW +: PW] <= '0;
            end else begin
                pix_valid[k] <= act;
                if (act) begin
                    left_pix[k*PW +: PW]  <= l0_left[rd_addr];
                    right_pix[k*PW +: PW] <= l0_right[rd_addr];
                end
            end
        end
    end
endmodule

// File: rtl/eyepyr_checker.sv
module eyepyr_checker #(
    parameter int CW = 10,
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_rd_en,
    input logic [CW-1:0] mem_x,
    input logic [CW-1:0] mem_y,
    input logic [NL-1:0] pix_valid,
    input logic [CW-1:0] box_l,
    input logic [CW-1:0] box_t,
    input logic [CW-1:0] box_r,
    input logic [CW-1:0] box_b
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_rd_en && pix_valid == '0));

    assert_read_inside_box_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_x >= box_l && mem_x <= box_r && mem_y >= box_t && mem_y <= box_b));

    assert_no_read_while_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|pix_valid) |-> !mem_rd_en);

    assert_output_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|pix_valid) |-> busy);

    for (genvar k = 1; k < NL; k++) begin : g_nest
        assert_small_level_within_large_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pix_valid[k] |-> pix_valid[0]);
    end

    assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_box_held_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(box_l) && $stable(box_t) && $stable(box_r) && $stable(box_b)));
endmodule

bind eyepyr_top eyepyr_checker #(.CW(CW), .NL(eyepyr_pkg::NUM_LEVELS)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .mem_x     (mem_x),
    .mem_y     (mem_y),
    .pix_valid (pix_valid),
    .box_l     (box_l_q),
    .box_t     (box_t_q),
    .box_r     (box_r_q),
    .box_b     (box_b_q)
);

// File: tb/test_eyepyr_top.sv
`timescale 1ns/1ps
module test_eyepyr_top;
    localparam int CW = 10;
    localparam int PW = 8;
    localparam int NL = 4;
    localparam int TW [NL] = '{33, 31, 29, 27};
    localparam int TH [NL] = '{36, 34, 32, 29};
    localparam int N0 = 33 * 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] face_left = '0, face_top = '0, face_right = '0, face_bottom = '0;
    logic mem_rd_en;
    logic [CW-1:0] mem_x, mem_y;
    logic [PW-1:0] mem_rdata = '0;
    logic busy, done;
    logic [NL-1:0] pix_valid;
    logic [NL*PW-1:0] left_pix, right_pix;

    always #10 clk = ~clk;

    eyepyr_top #(.CW(CW), .PW(PW)) i_eyepyr_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .face_left(face_left), .face_top(face_top),
        .face_right(face_right), .face_bottom(face_bottom),
        .mem_rd_en(mem_rd_en), .mem_x(mem_x), .mem_y(mem_y), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pix_valid(pix_valid),
        .left_pix(left_pix), .right_pix(right_pix)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // active box for expectations
    int bl, bt, br, bb, qw, qh;

    function automatic logic [7:0] pat(input int x, input int y);
        return 8'(x * 7 + y * 29 + (x >> 3) * 3);
    endfunction

    function automatic int exp_x(input int eye, input int c0);
        return eye ? br - (c0 * qw) / 33 : bl + (c0 * qw) / 33;
    endfunction

    function automatic int exp_y(input int r0);
        return bt + (r0 * qh) / 36;
    endfunction

    function automatic logic [7:0] exp_pix(input int eye, input int lvl, input int n);
        int r, c, r0, c0;
        r  = n / TW[lvl];
        c  = n % TW[lvl];
        r0 = (r * 36) / TH[lvl];
        c0 = (c * 33) / TW[lvl];
        return pat(exp_x(eye, c0), exp_y(r0));
    endfunction

    // frame memory model, one clock read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= pat(int'(mem_x), int'(mem_y));
    end

    // monitor
    int cyc = 0;
    int rd_cnt, addr_mis, done_cnt, done_cyc;
    int beat [NL];
    int first_c [NL];
    int last_c [NL];
    int mis_l [NL];
    int mis_r [NL];

    task automatic clear_mon();
        rd_cnt = 0; addr_mis = 0; done_cnt = 0; done_cyc = -1;
        for (int k = 0; k < NL; k++) begin
            beat[k] = 0; first_c[k] = -1; last_c[k] = -1; mis_l[k] = 0; mis_r[k] = 0;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_rd_en) begin
                int eye, m;
                eye = (rd_cnt >= N0) ? 1 : 0;
                m   = rd_cnt % N0;
                if (rd_cnt >= 2 * N0 || int'(mem_x) != exp_x(eye, m % 33) || int'(mem_y) != exp_y(m / 33))
                    addr_mis++;
                rd_cnt++;
            end
            for (int k = 0; k < NL; k++) begin
                if (pix_valid[k]) begin
                    if (beat[k] == 0) first_c[k] = cyc;
                    last_c[k] = cyc;
                    if (beat[k] < TW[k] * TH[k]) begin
                        if (left_pix[k*PW +: PW] != exp_pix(0, k, beat[k])) mis_l[k]++;
                        if (right_pix[k*PW +: PW] != exp_pix(1, k, beat[k])) mis_r[k]++;
                    end
                    beat[k]++;
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!busy && !done && !mem_rd_en && pix_valid == '0, "R1", "outputs in reset",
              int'({busy, done, mem_rd_en, pix_valid}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd_en && pix_valid == '0, "R1", "outputs idle after reset",
              int'({busy, done, mem_rd_en, pix_valid}), 0);
    endtask

    // one conversion; inject: pulse extra starts mid-run; up: quadrant smaller than target
    task automatic run_box(input int l, input int t, input int r, input int b, input bit inject, input bit up);
        bit finished;
        bl = l; bt = t; br = r; bb = b;
        qw = (r - l + 1) / 2;
        qh = (b - t + 1) / 2;
        clear_mon();
        @(negedge clk);
        face_left = CW'(l); face_top = CW'(t); face_right = CW'(r); face_bottom = CW'(b);
        start = 1'b1;
        finished = 1'b0;
        for (int n = 0; n < 8000 && !finished; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && (n == 500 || n == 3000)) begin
                start = 1'b1;
                face_left = 10'd5; face_top = 10'd6; face_right = 10'd500; face_bottom = 10'd470;
            end
            if (done_cnt > 0) finished = 1'b1;
        end
        start = 1'b0;
        check(finished, "R7", "conversion reached done", int'(finished), 1);
        repeat (6) @(negedge clk);
        check(rd_cnt == 2 * N0, "R2", "memory read count", rd_cnt, 2 * N0);
        check(addr_mis == 0, "R10", "read address mismatches", addr_mis, 0);
        check(mis_l[0] == 0, up ? "R9" : "R3", "left level0 pixel mismatches", mis_l[0], 0);
        check(mis_r[0] == 0, up ? "R9" : "R4", "right level0 pixel mismatches", mis_r[0], 0);
        for (int k = 1; k < NL; k++) begin
            check(mis_l[k] + mis_r[k] == 0, up ? "R9" : "R5", "smaller level pixel mismatches", mis_l[k] + mis_r[k], 0);
        end
        for (int k = 0; k < NL; k++) begin
            check(beat[k] == TW[k] * TH[k], "R6", "beats per level", beat[k], TW[k] * TH[k]);
            check(last_c[k] - first_c[k] + 1 == TW[k] * TH[k], "R6", "contiguous valid span",
                  last_c[k] - first_c[k] + 1, TW[k] * TH[k]);
            check(first_c[k] == first_c[0], "R6", "levels start together", first_c[k], first_c[0]);
        end
        check(done_cyc == last_c[0] + 1, "R7", "done cycle after last beat", done_cyc, last_c[0] + 1);
        check(done_cnt == 1, inject ? "R8" : "R7", "done pulse count", done_cnt, 1);
        check(!busy, inject ? "R8" : "R7", "busy clear after done", int'(busy), 0);
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        test_reset();
        run_box(100, 80, 299, 279, 1'b0, 1'b0);  // 100x100 quadrants, downsampling
        run_box(0, 0, 66, 72, 1'b0, 1'b0);       // quadrant equals level-0 size
        run_box(10, 10, 49, 39, 1'b0, 1'b1);     // 20x15 quadrants, upsampling
        run_box(300, 200, 539, 459, 1'b1, 1'b0); // starts injected while busy
        summary_and_end();
    end
endmodule